// File: doc/BRIEF.md
# Supply-Qualified Start-Up Sequencer

This controller brings a closed-loop magnetic current-sensing front end out of power-up in a fixed order and takes it back down when the supply sags. Two analog comparators report whether the supply is above an upper threshold (about 2.4 V) and above a lower threshold (about 1.8 V). The block filters those reports and emits a synchronous reset. It then steps through a settling wait, sensor power-up, an optional saturation search, an optional core demagnetization, and finally enables the compensation loop.

A dip below the upper threshold is tolerated as long as it stays within a configurable window. A longer dip, or any dip below the lower threshold, restarts everything. While the sequence is running, the coil driver is clamped low and the active-low error flag stays asserted. The search and demagnetization phases are each closed by a done pulse from their engines. All intervals are given in nanoseconds and converted to clock cycles from a clock-rate parameter.

Top module: `pwr_seq`

## Requirements
- R1: While `rst_n` is low, and after its release for as long as the supply is reported low, `phase` is 0 (reset), `por_rst` is 1, `drv_hold` is 1, `err_n` is 0 and all enables are 0.
- R2: `sup_hi_ok`, `sup_lo_ok` and `demag_req` are resynchronized by SYNC_STAGES flops. With the default of two stages, a simultaneous rise of both supply inputs moves `phase` to 1 (settle) on the third rising edge after the change.
- R3: Phase encoding is 0 reset, 1 settle, 2 sensor, 3 search, 4 demag, 5 run. Settle lasts exactly SETTLE_CYC cycles and then gives way to sensor with `sens_en` high. `sens_en` stays high in phases 2 to 5.
- R4: In sensor, a high `sat_det` enters search (`search_en` high) if no search has yet completed in this start-up. A `search_done` pulse returns the block to sensor, and no second search follows.
- R5: In sensor, once no search is pending, a synchronized high `demag_req` enters demag (`demag_en` high). A `demag_done` pulse moves the block to run on the next edge, regardless of elapsed time.
- R6: Without demag, run is entered DEADLINE_CYC cycles after the first settle cycle. If a search ends later than that, run follows one cycle after the return to sensor.
- R7: In run, `loop_en` is 1, `drv_hold` is 0 and `err_n` is 1. In every other phase `loop_en` is 0, `drv_hold` is 1 and `err_n` is 0.
- R8: A run of at most DIP_CYC consecutive synchronized low samples of `sup_hi_ok` (with `sup_lo_ok` high) leaves the phase and all outputs unchanged, and never raises `por_rst`.
- R9: On the (DIP_CYC+1)-th consecutive synchronized low sample of `sup_hi_ok`, `por_rst` rises in that cycle and `phase` is 0 from the next edge on.
- R10: A synchronized low sample of `sup_lo_ok` raises `por_rst` in the same cycle, with no filtering, and `phase` is 0 from the next edge on.
- R11: After any supply-triggered reset, the full sequence restarts from settle once the upper comparator again reads high.
- R12: A search or demag phase whose done input never arrives holds the block in that phase, with the loop disabled and `err_n` low, until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sup_hi_ok | input | 1 | Upper-threshold comparator, 1 = supply above |
| sup_lo_ok | input | 1 | Lower-threshold comparator, 1 = supply above |
| sat_det | input | 1 | Saturation flag from the sensor front end (synchronous) |
| demag_req | input | 1 | Demagnetization request pin (asynchronous) |
| search_done | input | 1 | Done pulse from the search engine |
| demag_done | input | 1 | Done pulse from the demag engine |
| por_rst | output | 1 | Synchronous reset to the rest of the sensor |
| sens_en | output | 1 | Sensor front-end enable |
| search_en | output | 1 | Search phase enable |
| demag_en | output | 1 | Demagnetization phase enable |
| loop_en | output | 1 | Compensation loop enable |
| drv_hold | output | 1 | Clamp coil driver outputs low |
| err_n | output | 1 | Active-low error flag |
| phase | output | 3 | Current phase code (see R3) |

## Verification
The assertions assume that `sat_det`, `search_done` and `demag_done` are synchronous to `clk`, and that each done input is a pulse presented only while its own phase is active. The bench drives every input on the falling edge, pulses each done flag for one cycle only after observing the matching phase, and holds the comparator inputs steady for whole cycles, so that dip lengths in cycles are exact. The assertions also rely on the comparator inputs being two-state after reset, which the bench guarantees by driving them from time zero.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [2:0] {
      PH_RESET  = 3'd0,
      PH_SETTLE = 3'd1,
      PH_SENSOR = 3'd2,
      PH_SEARCH = 3'd3,
      PH_DEMAG  = 3'd4,
      PH_RUN    = 3'd5
   } phase_e;

   // converts a duration in ns to whole clock cycles at the given kHz rate
   function automatic int unsigned ns_to_cyc(input int unsigned khz, input int unsigned ns);
      longint unsigned prod;
      prod = longint'(khz) * longint'(ns);
      return int'(prod / 64'd1000000);
   endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pwr_seq_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("pwr_seq_sync: W must be at least 1");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [W-1:0] r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= g_stg[i-1].r;
         end
      end
   end

   assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/pwr_seq_bod.sv
module pwr_seq_bod #(
   parameter int DIP_CYC = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hi_s,
   input  logic lo_s,
   output logic trip
);

   if (DIP_CYC < 0) begin : g_bad_dip
      $error("pwr_seq_bod: DIP_CYC must not be negative");
   end

   if (DIP_CYC == 0) begin : g_nofilt
      // no tolerance window: any low sample of either comparator resets
      assign trip = !lo_s || !hi_s;
   end else begin : g_filt
      localparam int CW = $clog2(DIP_CYC + 1);
      localparam logic [CW-1:0] CNT_MAX = CW'(DIP_CYC);

      logic [CW-1:0] dip_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                dip_cnt <= '0;
         else if (hi_s)             dip_cnt <= '0;
         else if (dip_cnt != CNT_MAX) dip_cnt <= dip_cnt + 1'b1;
      end

      assign trip = !lo_s || (!hi_s && dip_cnt == CNT_MAX);

      // R9: the dip counter saturates at the window length
      a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
         dip_cnt <= CNT_MAX);

      // R8: a filtered trip always follows an earlier low sample
      a_r8_dip_floor: assert property (@(posedge clk) disable iff (!rst_n)
         (trip && lo_s) |-> !$past(hi_s));
   end

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
   import pwr_seq_pkg::*;
#(
   parameter int SETTLE_CYC   = 6500,
   parameter int DEADLINE_CYC = 20000
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   trip,
   input  logic   hi_s,
   input  logic   demag_s,
   input  logic   sat_det,
   input  logic   search_done,
   input  logic   demag_done,
   output phase_e state,
   output logic   sens_en,
   output logic   search_en,
   output logic   demag_en,
   output logic   loop_en,
   output logic   drv_hold,
   output logic   err_n
);

   localparam int AW = $clog2(DEADLINE_CYC + 1);
   localparam logic [AW-1:0] SET_LAST = AW'(SETTLE_CYC - 1);
   localparam logic [AW-1:0] DL_LAST  = AW'(DEADLINE_CYC - 1);
   localparam logic [AW-1:0] AGE_MAX  = AW'(DEADLINE_CYC);

   phase_e        nxt;
   logic [AW-1:0] age;
   logic          searched;

   always_comb begin
      nxt = state;
      if (trip) begin
         nxt = PH_RESET;
      end else begin
         case (state)
            PH_RESET:  if (hi_s) nxt = PH_SETTLE;
            PH_SETTLE: if (age == SET_LAST) nxt = PH_SENSOR;
            PH_SENSOR: begin
               if (!searched && sat_det) nxt = PH_SEARCH;
               else if (demag_s)         nxt = PH_DEMAG;
               else if (age >= DL_LAST)  nxt = PH_RUN;
            end
            PH_SEARCH: if (search_done) nxt = PH_SENSOR;
            PH_DEMAG:  if (demag_done)  nxt = PH_RUN;
            PH_RUN:    nxt = PH_RUN;
            default:   nxt = PH_RESET;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PH_RESET;
         age      <= '0;
         searched <= 1'b0;
      end else begin
         state <= nxt;
         if (trip || state == PH_RESET) begin
            age      <= '0;
            searched <= 1'b0;
         end else begin
            if (age != AGE_MAX) age <= age + 1'b1;
            if (state == PH_SEARCH && search_done) searched <= 1'b1;
         end
      end
   end

   always_comb begin
      sens_en   = (state == PH_SENSOR) || (state == PH_SEARCH) ||
                  (state == PH_DEMAG)  || (state == PH_RUN);
      search_en = (state == PH_SEARCH);
      demag_en  = (state == PH_DEMAG);
      loop_en   = (state == PH_RUN);
      drv_hold  = (state != PH_RUN);
      err_n     = (state == PH_RUN);
   end

   // R3: settle hands over to sensor only after the full settle count
   a_r3_settle_len: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_SENSOR && $past(state) == PH_SETTLE) |-> age == AW'(SETTLE_CYC));

   // R5: run is entered only from sensor or demag
   a_r5_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_RUN && $past(state) != PH_RUN) |->
         ($past(state) == PH_SENSOR || $past(state) == PH_DEMAG));

   // R6: run reached from sensor never precedes the deadline
   a_r6_deadline: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_RUN && $past(state) == PH_SENSOR) |-> age >= AGE_MAX);

   // R12: a search without a done pulse holds its phase
   a_r12_search_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_SEARCH && !search_done && !trip) |=> state == PH_SEARCH);

   // R4: a completed search is never repeated in the same start-up
   a_r4_single_search: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_SEARCH && $past(state) != PH_SEARCH) |-> !$past(searched));

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
   import pwr_seq_pkg::*;
#(
   parameter int CLK_KHZ     = 250000,
   parameter int SETTLE_NS   = 26000,
   parameter int DIP_NS      = 20000,
   parameter int DEADLINE_NS = 80000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sup_hi_ok,
   input  logic       sup_lo_ok,
   input  logic       sat_det,
   input  logic       demag_req,
   input  logic       search_done,
   input  logic       demag_done,
   output logic       por_rst,
   output logic       sens_en,
   output logic       search_en,
   output logic       demag_en,
   output logic       loop_en,
   output logic       drv_hold,
   output logic       err_n,
   output logic [2:0] phase
);

   localparam int SETTLE_CYC   = int'(ns_to_cyc(CLK_KHZ, SETTLE_NS));
   localparam int DIP_CYC      = int'(ns_to_cyc(CLK_KHZ, DIP_NS));
   localparam int DEADLINE_CYC = int'(ns_to_cyc(CLK_KHZ, DEADLINE_NS));

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("pwr_seq: settle interval shorter than one cycle");
   end
   if (DEADLINE_CYC <= SETTLE_CYC) begin : g_bad_deadline
      $error("pwr_seq: loop deadline must exceed the settle interval");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwr_seq: at least two synchronizer stages are required");
   end

   logic [2:0] async_in;
   logic [2:0] sync_out;
   logic       hi_s;
   logic       lo_s;
   logic       demag_s;
   logic       trip;
   phase_e     state;

   assign async_in = {demag_req, sup_lo_ok, sup_hi_ok};

   pwr_seq_sync #(
      .W      (3),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (async_in),
      .q     (sync_out)
   );

   assign hi_s    = sync_out[0];
   assign lo_s    = sync_out[1];
   assign demag_s = sync_out[2];

   pwr_seq_bod #(
      .DIP_CYC (DIP_CYC)
   ) u_bod (
      .clk   (clk),
      .rst_n (rst_n),
      .hi_s  (hi_s),
      .lo_s  (lo_s),
      .trip  (trip)
   );

   pwr_seq_fsm #(
      .SETTLE_CYC   (SETTLE_CYC),
      .DEADLINE_CYC (DEADLINE_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .trip        (trip),
      .hi_s        (hi_s),
      .demag_s     (demag_s),
      .sat_det     (sat_det),
      .search_done (search_done),
      .demag_done  (demag_done),
      .state       (state),
      .sens_en     (sens_en),
      .search_en   (search_en),
      .demag_en    (demag_en),
      .loop_en     (loop_en),
      .drv_hold    (drv_hold),
      .err_n       (err_n)
   );

   assign por_rst = (state == PH_RESET) || trip;
   assign phase   = state;

   // R10: a deep dip forces the reset phase on the following edge
   a_r10_deep_dip: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_s |=> (phase == 3'd0 && por_rst));

   // R9: any trip from the filter lands in the reset phase
   a_r9_trip_resets: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> phase == 3'd0);

   // R11: leaving reset always goes to settle first
   a_r11_restart_order: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == PH_RESET && state != PH_RESET) |-> state == PH_SETTLE);

   // R7: the loop enable never coexists with a phase enable
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({search_en, demag_en, loop_en}));

endmodule

// File: tb/pwr_seq_bench.sv
module pwr_seq_bench;

   localparam int KHZ = 1000;
   localparam int SET = 26;
   localparam int DIP = 20;
   localparam int DL  = 80;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic hi = 1'b0, lo = 1'b0, sat = 1'b0, dmg = 1'b0, sdone = 1'b0, ddone = 1'b0;
   logic por_rst, sens_en, search_en, demag_en, loop_en, drv_hold, err_n;
   logic [2:0] phase;

   pwr_seq #(.CLK_KHZ(KHZ)) u_pwr_seq (
      .clk(clk), .rst_n(rst_n), .sup_hi_ok(hi), .sup_lo_ok(lo), .sat_det(sat),
      .demag_req(dmg), .search_done(sdone), .demag_done(ddone), .por_rst(por_rst),
      .sens_en(sens_en), .search_en(search_en), .demag_en(demag_en), .loop_en(loop_en),
      .drv_hold(drv_hold), .err_n(err_n), .phase(phase)
   );

   int  checks = 0;
   int  fails  = 0;
   bit  finished = 1'b0;
   bit  por_seen = 1'b0;
   bit  rst_seen = 1'b0;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // behavioural reference: history of sampled inputs plus phase timers
   int m_state = 0, m_age = 0, m_cnt = 0;
   bit m_srch = 0;
   bit hq[$], lq[$], dq[$];

   function automatic bit m_trip();
      return !lq[1] || (!hq[1] && m_cnt == DIP);
   endfunction

   initial begin
      hq = '{0, 0}; lq = '{0, 0}; dq = '{0, 0};
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_age = 0; m_cnt = 0; m_srch = 0;
         hq = '{0, 0}; lq = '{0, 0}; dq = '{0, 0};
      end else begin
         automatic bit t  = m_trip();
         automatic int ns = m_state;
         if (t) ns = 0;
         else if (m_state == 0 && hq[1]) ns = 1;
         else if (m_state == 1 && m_age == SET - 1) ns = 2;
         else if (m_state == 2) begin
            if (!m_srch && sat) ns = 3;
            else if (dq[1]) ns = 4;
            else if (m_age >= DL - 1) ns = 5;
         end
         else if (m_state == 3 && sdone) ns = 2;
         else if (m_state == 4 && ddone) ns = 5;
         if (t || m_state == 0) begin
            m_age = 0; m_srch = 0;
         end else begin
            if (m_age < DL) m_age++;
            if (m_state == 3 && sdone) m_srch = 1;
         end
         if (hq[1]) m_cnt = 0; else if (m_cnt < DIP) m_cnt++;
         m_state = ns;
         hq.pop_back(); hq.push_front(hi);
         lq.pop_back(); lq.push_front(lo);
         dq.pop_back(); dq.push_front(dmg);
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R3 phase vs model", phase, m_state);
         check("R9 por_rst vs model", por_rst, (m_state == 0 || m_trip()) ? 1 : 0);
         check("R3 sens_en vs model", sens_en, (m_state >= 2) ? 1 : 0);
         check("R4 search_en vs model", search_en, (m_state == 3) ? 1 : 0);
         check("R5 demag_en vs model", demag_en, (m_state == 4) ? 1 : 0);
         check("R7 loop_en vs model", loop_en, (m_state == 5) ? 1 : 0);
         check("R7 drv_hold vs model", drv_hold, (m_state != 5) ? 1 : 0);
         check("R7 err_n vs model", err_n, (m_state == 5) ? 1 : 0);
      end
      if (por_rst) por_seen = 1'b1;
      if (phase == 3'd0) rst_seen = 1'b1;
   end

   task automatic wait_phase(input int p, input int lim, output int n);
      n = 0;
      while (phase != 3'(p) && n < lim) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1: held in reset
      check("R1 phase in reset", phase, 0);
      check("R1 por_rst in reset", por_rst, 1);
      check("R1 drv_hold in reset", drv_hold, 1);
      check("R1 err_n in reset", err_n, 0);
      check("R1 loop_en in reset", loop_en, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 phase with supply low", phase, 0);
      check("R1 sens_en with supply low", sens_en, 0);

      // R2: detection latency
      hi = 1'b1; lo = 1'b1;
      wait_phase(1, 20, n);
      check("R2 detect latency", n, 3);

      // R3: settle length, then R6: deadline without search or demag
      n = 0;
      while (phase == 3'd1 && n < 200) begin
         @(negedge clk);
         n++;
      end
      check("R3 settle cycles", n, SET);
      check("R3 sensor phase", phase, 2);
      check("R3 sens_en", sens_en, 1);
      while (phase != 3'd5 && n < 300) begin
         @(negedge clk);
         n++;
      end
      check("R6 deadline cycles", n, DL);
      check("R7 loop_en in run", loop_en, 1);
      check("R7 drv_hold in run", drv_hold, 0);
      check("R7 err_n in run", err_n, 1);

      // R8: tolerated dip
      por_seen = 1'b0;
      hi = 1'b0;
      repeat (DIP) @(negedge clk);
      hi = 1'b1;
      repeat (6) @(negedge clk);
      check("R8 no reset on short dip", por_seen, 0);
      check("R8 still running", phase, 5);

      // R9: dip one sample too long
      por_seen = 1'b0;
      hi = 1'b0;
      repeat (DIP + 4) @(negedge clk);
      check("R9 reset raised", por_seen, 1);
      check("R9 phase reset", phase, 0);

      // R11: restart from settle
      hi = 1'b1;
      wait_phase(1, 20, n);
      check("R11 settle after recovery", n, 3);
      wait_phase(5, 200, n);
      check("R11 run after recovery", n, DL);

      // R10: one-cycle deep dip, then search and demag run
      por_seen = 1'b0; rst_seen = 1'b0;
      lo = 1'b0;
      @(negedge clk);
      lo = 1'b1; sat = 1'b1; dmg = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 reset on deep dip", por_seen, 1);
      check("R10 reset phase seen", rst_seen, 1);
      wait_phase(3, 100, n);
      check("R4 search entered", phase, 3);
      check("R4 search_en", search_en, 1);
      repeat (10) @(negedge clk);
      sdone = 1'b1;
      @(negedge clk);
      sdone = 1'b0;
      check("R4 back to sensor", phase, 2);
      @(negedge clk);
      check("R4 no second search, R5 demag", phase, 4);
      check("R5 demag_en", demag_en, 1);
      repeat (5) @(negedge clk);
      ddone = 1'b1;
      @(negedge clk);
      ddone = 1'b0;
      check("R5 run after demag done", phase, 5);

      // R12: search that never finishes
      dmg = 1'b0;
      lo = 1'b0;
      @(negedge clk);
      lo = 1'b1;
      wait_phase(3, 100, n);
      repeat (150) @(negedge clk);
      check("R12 stuck in search", phase, 3);
      check("R12 loop off", loop_en, 0);
      check("R12 err_n low", err_n, 0);

      // R6: late search completion goes to run one cycle after sensor
      sdone = 1'b1;
      @(negedge clk);
      sdone = 1'b0; sat = 1'b0;
      check("R6 sensor after late search", phase, 2);
      @(negedge clk);
      check("R6 run after late search", phase, 5);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule